// File: doc/BRIEF.md
# Per-Scanline DMA Slot Arbiter

This block decides, for every memory slot of a raster line, which bus master owns the shared chip memory. A slot counter runs along the line and a line counter runs down the frame. Each slot goes to exactly one owner. Bitplane fetches come first while the display fetch window is open. When no bitplane fetch takes the slot, the slot number and its parity select the candidate: odd slots are split into fixed regions for memory refresh, disk, the four audio channels and the eight sprites, and even slots are offered to the display-list coprocessor. A slot that no DMA channel claims goes to the processor.

The processor side also gets a wait controller. An access below the chip-memory limit is held until a slot that DMA leaves free has ended. It is then acknowledged, together with the number of slots it waited beyond the nominal one-slot access. An access above the limit is acknowledged after a single slot with no wait.

Top module: `dma_slot_arbiter`

## Requirements
- R1: While reset is high and in the first cycle after it, the slot position and the line position are 0 and the processor acknowledge is low.
- R2: The slot position counts up by one per clock and returns to 0 after the slot equal to `line_last_i`. The line position then advances by one, and returns to 0 after the line equal to `frame_last_i`.
- R3: When bitplane DMA is enabled, the vertical window input is high, the horizontal window is open and the bitplane channel requests, the slot goes to the bitplane channel (grant bit 0), whatever any other channel requests.
- R4: The horizontal window opens in the slot equal to `fetch_start_i`. It stays open up to, but not including, the slot `fetch_end_i + 12` in high resolution or `fetch_end_i + 8` in low resolution, taken modulo 256. It carries across line boundaries.
- R5: Odd slots 0x01, 0x03, 0x05 and 0x07 always go to refresh (grant bit 1) unless a bitplane fetch takes them.
- R6: Odd slots 0x09, 0x0B and 0x0D go to disk (grant bit 2) when disk DMA is enabled and the disk channel requests.
- R7: Odd slots 0x0F to 0x15 go to audio channel (slot - 0x0E) >> 1 (grant bit 3 + channel) when that channel's enable bit and request are both set.
- R8: Odd slots 0x17 to 0x35 go to sprite (slot - 0x16) >> 2 (grant bit 7 + sprite) when sprite DMA is enabled, the sprite requests and the line position is at least `vblank_line_i`. The word select output then equals the inverse of slot bit 1.
- R9: Even slots go to the coprocessor (grant bit 15) when its DMA is enabled and it requests. The position word output is {line[7:0], slot[7:0]}.
- R10: Exactly one grant bit is high in every slot. Bit 16 (processor) is high, together with `cpu_slot_o`, exactly when no DMA channel claims the slot.
- R11: A processor request with an address below 0x200000 is acknowledged for one cycle, in the cycle after the first slot in which `cpu_slot_o` is high. The wait output then gives the number of slots that passed before that free slot. A request at or above 0x200000 is acknowledged in the cycle after it is raised, with a wait of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one memory slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| line_last_i | input | 8 | Index of the last slot in a line |
| frame_last_i | input | 9 | Index of the last line in a frame |
| vblank_line_i | input | 9 | First line in which sprite DMA may run |
| hires_i | input | 1 | High resolution selects the longer fetch tail |
| fetch_start_i | input | 8 | Slot that opens the horizontal fetch window |
| fetch_end_i | input | 8 | Programmed end of the horizontal fetch window |
| vfetch_open_i | input | 1 | Vertical fetch window open |
| en_bpl_i | input | 1 | Bitplane DMA enable |
| en_disk_i | input | 1 | Disk DMA enable |
| en_aud_i | input | 4 | Per-channel audio DMA enables |
| en_spr_i | input | 1 | Sprite DMA enable |
| en_cop_i | input | 1 | Coprocessor DMA enable |
| req_bpl_i | input | 1 | Bitplane channel wants the slot |
| req_disk_i | input | 1 | Disk channel wants the slot |
| req_aud_i | input | 4 | Audio channels want a slot |
| req_spr_i | input | 8 | Sprites want a slot |
| req_cop_i | input | 1 | Coprocessor wants the slot |
| cpu_req_i | input | 1 | Processor access pending, held until acknowledged |
| cpu_addr_i | input | 24 | Processor access address |
| hpos_o | output | 8 | Current slot position |
| vpos_o | output | 9 | Current line position |
| grant_o | output | 17 | One-hot slot owner |
| cpu_slot_o | output | 1 | Slot is free for the processor |
| spr_word_o | output | 1 | Sprite word select for the current slot |
| cop_pos_o | output | 16 | Raster position word for the coprocessor |
| cpu_ack_o | output | 1 | Processor access complete (one cycle) |
| cpu_stall_o | output | 8 | Slots waited beyond nominal, valid with the acknowledge |

## Verification
Every slot of a small six-line frame is swept and compared against an arithmetic model. The sweep runs once with all DMA off, which leaves refresh and processor slots only. It runs with everything enabled and requesting, which shows each region boundary and the sprite blanking lines. It runs with a sparse mix of audio and sprite enables and requests, which checks that each grant follows the right channel index and not merely the region. Two bitplane windows, one in low and one in high resolution, check that the fetch overrides the regions and that the window stops at the right tail. Processor accesses are started in busy and in free slots, to chip and to non-chip addresses, so that a wait of zero, a short wait and a long wait can each be told apart.

// File: rtl/slot_arb_pkg.sv
`timescale 1ns/1ps
package slot_arb_pkg;

    localparam int SLOT_W = 8;
    localparam int LINE_W = 9;
    localparam int N_AUD  = 4;
    localparam int N_SPR  = 8;

    // grant vector layout
    localparam int GB_BPL = 0;
    localparam int GB_REF = 1;
    localparam int GB_DSK = 2;
    localparam int GB_AUD = 3;
    localparam int GB_SPR = GB_AUD + N_AUD;
    localparam int GB_COP = GB_SPR + N_SPR;
    localparam int GB_CPU = GB_COP + 1;
    localparam int N_GNT  = GB_CPU + 1;

    // odd-slot region boundaries (exclusive upper bounds)
    localparam logic [SLOT_W-1:0] REF_END = SLOT_W'(8'h08);
    localparam logic [SLOT_W-1:0] DSK_END = SLOT_W'(8'h0E);
    localparam logic [SLOT_W-1:0] AUD_LO  = SLOT_W'(8'h0E);
    localparam logic [SLOT_W-1:0] AUD_END = SLOT_W'(8'h16);
    localparam logic [SLOT_W-1:0] SPR_LO  = SLOT_W'(8'h16);
    localparam logic [SLOT_W-1:0] SPR_END = SLOT_W'(8'h36);

    localparam int HIRES_TAIL = 12;
    localparam int LORES_TAIL = 8;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_REFRESH,
        RG_DISK,
        RG_AUDIO,
        RG_SPRITE
    } odd_region_e;

    typedef struct packed {
        logic             bpl;
        logic             disk;
        logic [N_AUD-1:0] aud;
        logic             spr;
        logic             cop;
    } dma_en_t;

    typedef struct packed {
        logic             bpl;
        logic             disk;
        logic [N_AUD-1:0] aud;
        logic [N_SPR-1:0] spr;
        logic             cop;
    } dma_req_t;

    function automatic odd_region_e region_of(input logic [SLOT_W-1:0] h);
        if (h < REF_END)      return RG_REFRESH;
        else if (h < DSK_END) return RG_DISK;
        else if (h < AUD_END) return RG_AUDIO;
        else if (h < SPR_END) return RG_SPRITE;
        else                  return RG_NONE;
    endfunction

    function automatic logic [SLOT_W-1:0] fetch_stop(input logic [SLOT_W-1:0] fend,
                                                     input logic hires);
        return fend + (hires ? SLOT_W'(HIRES_TAIL) : SLOT_W'(LORES_TAIL));
    endfunction

endpackage

// File: rtl/raster_counter.sv
`timescale 1ns/1ps
module raster_counter
    import slot_arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SLOT_W-1:0] line_last_i,
    input  logic [LINE_W-1:0] frame_last_i,
    output logic [SLOT_W-1:0] hpos_o,
    output logic [LINE_W-1:0] vpos_o
);
    logic [SLOT_W-1:0] hpos_q;
    logic [LINE_W-1:0] vpos_q;
    logic              eol;

    assign eol = (hpos_q == line_last_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            hpos_q <= '0;
            vpos_q <= '0;
        end else if (eol) begin
            hpos_q <= '0;
            vpos_q <= (vpos_q == frame_last_i) ? '0 : vpos_q + 1'b1;
        end else begin
            hpos_q <= hpos_q + 1'b1;
        end
    end

    assign hpos_o = hpos_q;
    assign vpos_o = vpos_q;

    // R2
    line_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (hpos_q == line_last_i) |=> (hpos_q == '0));

    // R2
    slot_step_chk: assert property (@(posedge clk) disable iff (rst)
        (hpos_q != line_last_i) |=> (hpos_q != '0));

endmodule

// File: rtl/fetch_window.sv
`timescale 1ns/1ps
module fetch_window
    import slot_arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SLOT_W-1:0] hpos_i,
    input  logic [SLOT_W-1:0] start_i,
    input  logic [SLOT_W-1:0] end_i,
    input  logic              hires_i,
    output logic              open_o
);
    logic              open_q;
    logic [SLOT_W-1:0] stop_pos;

    assign stop_pos = fetch_stop(end_i, hires_i);
    assign open_o   = (open_q || (hpos_i == start_i)) && (hpos_i != stop_pos);

    always_ff @(posedge clk) begin
        if (rst) open_q <= 1'b0;
        else     open_q <= open_o;
    end

    // R4
    win_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (open_q && hpos_i != stop_pos) |-> open_o);

    // R4
    win_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (hpos_i == stop_pos) |=> !open_q);

endmodule

// File: rtl/slot_decoder.sv
`timescale 1ns/1ps
module slot_decoder
    import slot_arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SLOT_W-1:0] hpos_i,
    input  logic [LINE_W-1:0] vpos_i,
    input  logic [LINE_W-1:0] vblank_i,
    input  dma_en_t           en_i,
    input  dma_req_t          req_i,
    input  logic              bpl_ok_i,
    output logic [N_GNT-1:0]  grant_o,
    output logic              spr_word_o,
    output logic [15:0]       cop_pos_o
);
    localparam int AW = $clog2(N_AUD);
    localparam int SW = $clog2(N_SPR);

    logic              odd;
    odd_region_e       rg;
    logic [SLOT_W-1:0] aoff, soff;
    logic [AW-1:0]     aidx;
    logic [SW-1:0]     sidx;
    logic              spr_line_ok;
    logic              ref_hit, dsk_hit, cop_hit;
    logic [N_AUD-1:0]  aud_hit;
    logic [N_SPR-1:0]  spr_hit;
    logic [N_GNT-1:0]  g;

    assign odd         = hpos_i[0];
    assign rg          = region_of(hpos_i);
    assign aoff        = hpos_i - AUD_LO;
    assign soff        = hpos_i - SPR_LO;
    assign aidx        = aoff[AW:1];
    assign sidx        = soff[SW+1:2];
    assign spr_line_ok = (vpos_i >= vblank_i);

    assign ref_hit = odd && (rg == RG_REFRESH);
    assign dsk_hit = odd && (rg == RG_DISK) && en_i.disk && req_i.disk;
    assign cop_hit = !odd && en_i.cop && req_i.cop;

    for (genvar a = 0; a < N_AUD; a++) begin : g_aud
        assign aud_hit[a] = odd && (rg == RG_AUDIO) && (aidx == AW'(a))
                            && en_i.aud[a] && req_i.aud[a];
    end

    for (genvar s = 0; s < N_SPR; s++) begin : g_spr
        assign spr_hit[s] = odd && (rg == RG_SPRITE) && (sidx == SW'(s))
                            && en_i.spr && spr_line_ok && req_i.spr[s];
    end

    always_comb begin
        g = '0;
        if (bpl_ok_i) begin
            g[GB_BPL] = 1'b1;
        end else begin
            g[GB_REF]            = ref_hit;
            g[GB_DSK]            = dsk_hit;
            g[GB_AUD +: N_AUD]   = aud_hit;
            g[GB_SPR +: N_SPR]   = spr_hit;
            g[GB_COP]            = cop_hit;
        end
        g[GB_CPU] = ~|g;
    end

    assign grant_o    = g;
    assign spr_word_o = ~hpos_i[1];
    assign cop_pos_o  = {vpos_i[7:0], hpos_i};

    // R10
    one_owner_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(grant_o) == 1);

    // R9
    cop_even_chk: assert property (@(posedge clk) disable iff (rst)
        grant_o[GB_COP] |-> !hpos_i[0]);

    // R5
    refresh_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (hpos_i[0] && hpos_i < REF_END && !bpl_ok_i) |-> grant_o[GB_REF]);

    // R8
    sprite_blank_chk: assert property (@(posedge clk) disable iff (rst)
        (vpos_i < vblank_i) |-> (grant_o[GB_SPR +: N_SPR] == '0));

endmodule

// File: rtl/cpu_stall.sv
`timescale 1ns/1ps
module cpu_stall #(
    parameter int          ADDR_W     = 24,
    parameter int          STALL_W    = 8,
    parameter logic [31:0] CHIP_LIMIT = 32'h0020_0000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               free_i,
    output logic               ack_o,
    output logic [STALL_W-1:0] stall_o
);
    localparam logic [STALL_W-1:0] STALL_MAX = '1;

    logic               ack_q;
    logic [STALL_W-1:0] cnt_q, stall_q;
    logic               chip, active, done;

    assign chip   = ({{(32-ADDR_W){1'b0}}, addr_i} < CHIP_LIMIT);
    assign active = req_i && !ack_q;
    assign done   = active && (!chip || free_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q   <= 1'b0;
            cnt_q   <= '0;
            stall_q <= '0;
        end else begin
            ack_q <= done;
            if (done) begin
                stall_q <= chip ? cnt_q : '0;
                cnt_q   <= '0;
            end else if (active && cnt_q != STALL_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign ack_o   = ack_q;
    assign stall_o = stall_q;

    // R11
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ack_q |=> !ack_q);

    // R11
    fast_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (active && !chip) |=> (ack_q && stall_q == '0));

endmodule

// File: rtl/dma_slot_arbiter.sv
`timescale 1ns/1ps
module dma_slot_arbiter
    import slot_arb_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int STALL_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [7:0]         line_last_i,
    input  logic [8:0]         frame_last_i,
    input  logic [8:0]         vblank_line_i,
    input  logic               hires_i,
    input  logic [7:0]         fetch_start_i,
    input  logic [7:0]         fetch_end_i,
    input  logic               vfetch_open_i,
    input  logic               en_bpl_i,
    input  logic               en_disk_i,
    input  logic [3:0]         en_aud_i,
    input  logic               en_spr_i,
    input  logic               en_cop_i,
    input  logic               req_bpl_i,
    input  logic               req_disk_i,
    input  logic [3:0]         req_aud_i,
    input  logic [7:0]         req_spr_i,
    input  logic               req_cop_i,
    input  logic               cpu_req_i,
    input  logic [ADDR_W-1:0]  cpu_addr_i,
    output logic [7:0]         hpos_o,
    output logic [8:0]         vpos_o,
    output logic [16:0]        grant_o,
    output logic               cpu_slot_o,
    output logic               spr_word_o,
    output logic [15:0]        cop_pos_o,
    output logic               cpu_ack_o,
    output logic [STALL_W-1:0] cpu_stall_o
);
    logic [SLOT_W-1:0] hpos;
    logic [LINE_W-1:0] vpos;
    logic              hwin;
    logic              bpl_ok;
    dma_en_t           en;
    dma_req_t          req;
    logic [N_GNT-1:0]  grant;

    assign en  = '{bpl: en_bpl_i, disk: en_disk_i, aud: en_aud_i,
                   spr: en_spr_i, cop: en_cop_i};
    assign req = '{bpl: req_bpl_i, disk: req_disk_i, aud: req_aud_i,
                   spr: req_spr_i, cop: req_cop_i};

    raster_counter u_raster (
        .clk          (clk),
        .rst          (rst),
        .line_last_i  (line_last_i),
        .frame_last_i (frame_last_i),
        .hpos_o       (hpos),
        .vpos_o       (vpos)
    );

    fetch_window u_window (
        .clk     (clk),
        .rst     (rst),
        .hpos_i  (hpos),
        .start_i (fetch_start_i),
        .end_i   (fetch_end_i),
        .hires_i (hires_i),
        .open_o  (hwin)
    );

    assign bpl_ok = en.bpl && req.bpl && vfetch_open_i && hwin;

    slot_decoder u_decode (
        .clk        (clk),
        .rst        (rst),
        .hpos_i     (hpos),
        .vpos_i     (vpos),
        .vblank_i   (vblank_line_i),
        .en_i       (en),
        .req_i      (req),
        .bpl_ok_i   (bpl_ok),
        .grant_o    (grant),
        .spr_word_o (spr_word_o),
        .cop_pos_o  (cop_pos_o)
    );

    cpu_stall #(
        .ADDR_W  (ADDR_W),
        .STALL_W (STALL_W)
    ) u_stall (
        .clk     (clk),
        .rst     (rst),
        .req_i   (cpu_req_i),
        .addr_i  (cpu_addr_i),
        .free_i  (grant[GB_CPU]),
        .ack_o   (cpu_ack_o),
        .stall_o (cpu_stall_o)
    );

    assign hpos_o     = hpos;
    assign vpos_o     = vpos;
    assign grant_o    = grant;
    assign cpu_slot_o = grant[GB_CPU];

    // R3
    bpl_preempt_chk: assert property (@(posedge clk) disable iff (rst)
        (en_bpl_i && req_bpl_i && vfetch_open_i && hwin) |-> grant_o[GB_BPL]);

    // R10
    cpu_free_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_slot_o |-> (grant_o[GB_CPU-1:0] == '0));

endmodule

// File: tb/sim_dma_slot_arbiter.sv
`timescale 1ns/1ps
module sim_dma_slot_arbiter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  line_last = 8'h3F;
    logic [8:0]  frame_last = 9'd5;
    logic [8:0]  vblank = 9'd2;
    logic        hires = 1'b0;
    logic [7:0]  fstart = 8'h00;
    logic [7:0]  fend = 8'h00;
    logic        vwin = 1'b0;
    logic        en_bpl = 0, en_disk = 0, en_spr = 0, en_cop = 0;
    logic [3:0]  en_aud = 4'h0;
    logic        req_bpl = 0, req_disk = 0, req_cop = 0;
    logic [3:0]  req_aud = 4'h0;
    logic [7:0]  req_spr = 8'h00;
    logic        cpu_req = 1'b0;
    logic [23:0] cpu_addr = 24'h0;

    logic [7:0]  hpos;
    logic [8:0]  vpos;
    logic [16:0] grant;
    logic        cpu_slot, spr_word, cpu_ack;
    logic [15:0] cop_pos;
    logic [7:0]  cpu_stall;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    int mh = 0;
    int mv = 0;
    bit mhw = 0;

    always #10 clk = ~clk;

    dma_slot_arbiter u0 (
        .clk(clk), .rst(rst),
        .line_last_i(line_last), .frame_last_i(frame_last),
        .vblank_line_i(vblank), .hires_i(hires),
        .fetch_start_i(fstart), .fetch_end_i(fend), .vfetch_open_i(vwin),
        .en_bpl_i(en_bpl), .en_disk_i(en_disk), .en_aud_i(en_aud),
        .en_spr_i(en_spr), .en_cop_i(en_cop),
        .req_bpl_i(req_bpl), .req_disk_i(req_disk), .req_aud_i(req_aud),
        .req_spr_i(req_spr), .req_cop_i(req_cop),
        .cpu_req_i(cpu_req), .cpu_addr_i(cpu_addr),
        .hpos_o(hpos), .vpos_o(vpos), .grant_o(grant),
        .cpu_slot_o(cpu_slot), .spr_word_o(spr_word), .cop_pos_o(cop_pos),
        .cpu_ack_o(cpu_ack), .cpu_stall_o(cpu_stall)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // R4: window open test from the bench's own copy of the window state
    function automatic bit model_hwin();
        int stop = (fend + (hires ? 12 : 8)) % 256;
        return (mhw || mh == fstart) && (mh != stop);
    endfunction

    function automatic logic [16:0] model_grant();
        logic [16:0] g = '0;
        if (en_bpl && req_bpl && vwin && model_hwin()) g[0] = 1'b1;
        else if (mh % 2 == 1) begin
            if (mh < 8) g[1] = 1'b1;
            else if (mh < 14) begin
                if (en_disk && req_disk) g[2] = 1'b1;
            end else if (mh < 22) begin
                int ch = (mh - 14) / 2;
                if (en_aud[ch] && req_aud[ch]) g[3 + ch] = 1'b1;
            end else if (mh < 54) begin
                int sp = (mh - 22) / 4;
                if (en_spr && req_spr[sp] && mv >= vblank) g[7 + sp] = 1'b1;
            end
        end else if (en_cop && req_cop) g[15] = 1'b1;
        if (g == '0) g[16] = 1'b1;
        return g;
    endfunction

    function automatic string tag_of(input logic [16:0] g);
        if (g[0])          return "R3";
        if (g[1])          return "R5";
        if (g[2])          return "R6";
        if (|g[6:3])       return "R7";
        if (|g[14:7])      return "R8";
        if (g[15])         return "R9";
        return "R10";
    endfunction

    task automatic step();
        bit hw = model_hwin();
        @(posedge clk);
        mhw = hw;
        if (mh == line_last) begin
            mh = 0;
            mv = (mv == frame_last) ? 0 : mv + 1;
        end else mh++;
        @(negedge clk);
    endtask

    task automatic check_slot();
        logic [16:0] eg;
        #1;
        eg = model_grant();
        check(hpos == mh[7:0], "R2", "slot position", hpos, mh);
        check(vpos == mv[8:0], "R2", "line position", vpos, mv);
        check(grant == eg, tag_of(eg), "grant", grant, eg);
        check(cpu_slot == eg[16], "R10", "cpu slot flag", cpu_slot, eg[16]);
        if (|eg[14:7])
            check(spr_word == !mh[1], "R8", "sprite word", spr_word, !mh[1]);
        if (eg[15])
            check(cop_pos == {mv[7:0], mh[7:0]}, "R9", "coproc position",
                  cop_pos, {mv[7:0], mh[7:0]});
    endtask

    task automatic sweep_frame();
        int n = (line_last + 1) * (frame_last + 1);
        for (int i = 0; i < n; i++) begin
            check_slot();
            step();
        end
    endtask

    task automatic align(input int h);
        while (mh != h) step();
    endtask

    // R11: chip access waits for a free slot, other addresses complete at once
    task automatic cpu_access(input logic [23:0] addr);
        int waited = 0;
        bit chip = (addr < 24'h200000);
        cpu_addr = addr;
        cpu_req  = 1'b1;
        for (int k = 0; k < 1000; k++) begin
            logic [16:0] eg;
            bit done;
            #1;
            eg = model_grant();
            check(cpu_ack == 1'b0, "R11", "early ack", cpu_ack, 0);
            done = !chip || eg[16];
            step();
            if (done) break;
            waited++;
        end
        #1;
        check(cpu_ack == 1'b1, "R11", "ack", cpu_ack, 1);
        check(cpu_stall == (chip ? waited[7:0] : 8'd0), "R11", "stall count",
              cpu_stall, chip ? waited : 0);
        cpu_req = 1'b0;
        step();
        #1;
        check(cpu_ack == 1'b0, "R11", "ack pulse width", cpu_ack, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check(hpos == 0, "R1", "reset slot", hpos, 0);
        check(vpos == 0, "R1", "reset line", vpos, 0);
        check(cpu_ack == 0, "R1", "reset ack", cpu_ack, 0);
        rst = 1'b0;
        @(negedge clk);
        mh = 1; mv = 0; mhw = 0;
        #1;
        check(cpu_ack == 0, "R1", "ack after reset", cpu_ack, 0);

        // all DMA off: refresh and processor only (R5, R10)
        req_disk = 1; req_aud = 4'hF; req_spr = 8'hFF; req_cop = 1; req_bpl = 1;
        sweep_frame();

        // every channel on and asking: region boundaries, sprite blanking (R6..R9)
        en_disk = 1; en_aud = 4'hF; en_spr = 1; en_cop = 1;
        sweep_frame();

        // sparse mix: grants follow channel indexes (R7, R8)
        en_disk = 0; en_aud = 4'b0101; req_aud = 4'b0011;
        req_spr = 8'b1010_0101; req_cop = 0; vblank = 9'd4;
        sweep_frame();

        // low-resolution bitplane window (R3, R4)
        en_bpl = 1; vwin = 1; fstart = 8'h10; fend = 8'h20; hires = 0;
        req_cop = 1; en_disk = 1;
        sweep_frame();

        // high-resolution tail, window wrapping across the line end (R4)
        hires = 1; fstart = 8'h30; fend = 8'h38;
        sweep_frame();

        // vertical window closed blocks bitplane (R3)
        vwin = 0;
        sweep_frame();

        // processor accesses with copper on every even slot (R11)
        en_bpl = 0; vblank = 9'd0;
        en_aud = 4'hF; req_aud = 4'hF; req_spr = 8'hFF;
        align(0);
        cpu_access(24'h00_1000);
        align(8'h38);
        cpu_access(24'h1F_FFFE);
        align(4);
        cpu_access(24'hC0_0000);
        align(8'h3A);
        cpu_access(24'h20_0000);
        en_cop = 0;
        align(2);
        cpu_access(24'h00_0010);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog R11 actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule